// File: doc/BRIEF.md
# Banked Memory Window Controller

This block lets an 8-bit processor with a 16-bit address bus reach a 512 KB physical memory. It does this through a 16 KB window at CPU addresses $8000 to $BFFF. A 5-bit bank number chooses which 16 KB slice of physical memory appears in that window. Every other CPU address maps one-to-one onto the lowest 64 KB of physical memory. Because of this, code, stack and I/O outside the window can always be reached, whatever bank is selected.

Software selects a bank by writing to any address in the $DExx page. It can read the current bank back from the same page. The register is clocked by the common system clock, and the decoded write acts only as a clock enable. The physical address is formed combinationally from the current CPU address in the same cycle. A new bank value takes effect from the next clock cycle.

Top module: `bankwin_top`

## Requirements
- R1: While reset is asserted, and after it is released, the bank value is 0. A read of $DExx returns 0, and window accesses map to physical $00000-$03FFF. Asserting reset at any time clears the bank.
- R2: Physical address bits 13:0 always equal CPU address bits 13:0, in the same cycle.
- R3: A cycle with `cpu_wr`=1 and CPU address bits 15:8 = $DE loads the bank from `cpu_wdata` bits 4:0. Data bits 7:5 are ignored.
- R4: For CPU addresses $8000-$BFFF (address bits 15:14 = 2'b10), physical address bits 18:14 equal the bank value.
- R5: For all other CPU addresses, physical bits 18:16 are 0 and physical bits 15:0 equal the CPU address, for any bank value.
- R6: When `cpu_rd`=1 and address bits 15:8 = $DE, `rd_oe` is 1 and `rd_data` = {3'b000, bank}. In every other cycle, `rd_oe` is 0 and `rd_data` is 0.
- R7: A bank write is seen by accesses from the next clock cycle on. A read-back in the same cycle as the write returns the old bank.
- R8: A write outside the $DExx page, or a $DExx access without `cpu_wr`, leaves the bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe for the current cycle |
| cpu_rd | input | 1 | Read strobe for the current cycle |
| phys_addr | output | 19 | Physical memory address |
| rd_data | output | 8 | Bank read-back data (0 when not enabled) |
| rd_oe | output | 1 | Read-back drive enable |

## Verification
The address mapping is exercised with addresses at both edges of the window and in each of the three quarters outside it. Each is tried under bank 0, a middle bank and the all-ones bank. This separates a correct window decode from one that applies the bank everywhere, or that is off by one quarter at $7FFF/$8000 and $BFFF/$C000. Writes are made with the upper data bits set, to pages next to $DE, and with the write strobe low. These show whether the page decode is exact and whether only bits 4:0 are stored. A read-back in the same cycle as a write, and a reset asserted in the middle of a run, fix when a new bank becomes visible and when it is cleared.

// File: rtl/bankwin_pkg.sv
package bankwin_pkg;
  parameter int CPU_AW  = 16;
  parameter int DATA_W  = 8;
  parameter int BANK_W  = 5;
  parameter int WIN_W   = 14;
  parameter int PHYS_AW = WIN_W + BANK_W;
  parameter int SLOT_W  = CPU_AW - WIN_W;
  parameter int PAGE_W  = CPU_AW - 8;
  parameter logic [SLOT_W-1:0] WIN_SLOT = 2'b10;
  parameter logic [PAGE_W-1:0] IO_PAGE  = 8'hDE;
endpackage

// File: rtl/bankwin_rst_sync.sv
module bankwin_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bankwin_decode.sv
module bankwin_decode
  import bankwin_pkg::*;
(
  input  logic [CPU_AW-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              in_window,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic page_hit;

  always_comb begin
    in_window = (addr[CPU_AW-1:WIN_W] == WIN_SLOT);
    page_hit  = (addr[CPU_AW-1:8] == IO_PAGE);
    wr_hit    = wr & page_hit;
    rd_hit    = rd & page_hit;
  end
endmodule

// File: rtl/bankwin_bank_reg.sv
module bankwin_bank_reg
  import bankwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [BANK_W-1:0] load_val,
  output logic [BANK_W-1:0] bank_q
);
  logic [BANK_W-1:0] bank_d;

  always_comb begin
    bank_d = bank_q;
    if (load_en) bank_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end
endmodule

// File: rtl/bankwin_map.sv
module bankwin_map
  import bankwin_pkg::*;
(
  input  logic [CPU_AW-1:0]  addr,
  input  logic               in_window,
  input  logic [BANK_W-1:0]  bank,
  output logic [PHYS_AW-1:0] phys
);
  logic [PHYS_AW-1:0] ident;

  generate
    if (PHYS_AW > CPU_AW) begin : g_ext
      assign ident = {{(PHYS_AW-CPU_AW){1'b0}}, addr};
    end else begin : g_trunc
      assign ident = addr[PHYS_AW-1:0];
    end
  endgenerate

  always_comb begin
    phys = ident;
    if (in_window) phys = {bank, addr[WIN_W-1:0]};
  end
endmodule

// File: rtl/bankwin_top.sv
module bankwin_top
  import bankwin_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  input  logic               cpu_wr,
  input  logic               cpu_rd,
  output logic [PHYS_AW-1:0] phys_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_oe
);
  logic              rst_sync_n;
  logic              in_window;
  logic              wr_hit;
  logic              rd_hit;
  logic [BANK_W-1:0] bank_val;
  logic              unused_hi;

  assign unused_hi = ^cpu_wdata[DATA_W-1:BANK_W];

  bankwin_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bankwin_decode u_dec (
    .addr      (cpu_addr),
    .wr        (cpu_wr),
    .rd        (cpu_rd),
    .in_window (in_window),
    .wr_hit    (wr_hit),
    .rd_hit    (rd_hit)
  );

  bankwin_bank_reg u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (wr_hit),
    .load_val (cpu_wdata[BANK_W-1:0]),
    .bank_q   (bank_val)
  );

  bankwin_map u_map (
    .addr      (cpu_addr),
    .in_window (in_window),
    .bank      (bank_val),
    .phys      (phys_addr)
  );

  always_comb begin
    rd_oe   = rd_hit;
    rd_data = '0;
    if (rd_hit) rd_data = {{(DATA_W-BANK_W){1'b0}}, bank_val};
  end
endmodule

// File: rtl/bankwin_chk.sv
module bankwin_chk
  import bankwin_pkg::*;
(
  input logic               clk,
  input logic               rst_ok,
  input logic [CPU_AW-1:0]  cpu_addr,
  input logic [DATA_W-1:0]  cpu_wdata,
  input logic               cpu_wr,
  input logic               cpu_rd,
  input logic [PHYS_AW-1:0] phys_addr,
  input logic [DATA_W-1:0]  rd_data,
  input logic               rd_oe,
  input logic [BANK_W-1:0]  bank
);
  logic win_c, page_c;
  assign win_c  = (cpu_addr[CPU_AW-1:WIN_W] == WIN_SLOT);
  assign page_c = (cpu_addr[CPU_AW-1:8] == IO_PAGE);

  a_r2_low_pass: assert property (@(posedge clk) disable iff (!rst_ok)
    phys_addr[WIN_W-1:0] == cpu_addr[WIN_W-1:0]);

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_wr && page_c) |=> (bank == $past(cpu_wdata[BANK_W-1:0])));

  a_r4_window: assert property (@(posedge clk) disable iff (!rst_ok)
    win_c |-> (phys_addr[PHYS_AW-1:WIN_W] == bank));

  a_r5_identity: assert property (@(posedge clk) disable iff (!rst_ok)
    !win_c |-> (phys_addr == PHYS_AW'(cpu_addr)));

  a_r6_readback: assert property (@(posedge clk) disable iff (!rst_ok)
    (cpu_rd && page_c) |-> (rd_oe && rd_data == DATA_W'(bank)));

  a_r6_quiet: assert property (@(posedge clk) disable iff (!rst_ok)
    !(cpu_rd && page_c) |-> (!rd_oe && rd_data == '0));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !(cpu_wr && page_c) |=> $stable(bank));
endmodule

bind bankwin_top bankwin_chk u_chk (
  .clk       (clk),
  .rst_ok    (rst_sync_n),
  .cpu_addr  (cpu_addr),
  .cpu_wdata (cpu_wdata),
  .cpu_wr    (cpu_wr),
  .cpu_rd    (cpu_rd),
  .phys_addr (phys_addr),
  .rd_data   (rd_data),
  .rd_oe     (rd_oe),
  .bank      (bank_val)
);

// File: tb/sim_bankwin_top.sv
`timescale 1ns/1ps
module sim_bankwin_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_wr;
  logic        cpu_rd;
  logic [18:0] phys_addr;
  logic [7:0]  rd_data;
  logic        rd_oe;

  int checks = 0;
  int fails  = 0;
  logic [4:0] model_bank = 5'd0;

  always #2.5 clk = ~clk;

  bankwin_top u0 (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .phys_addr(phys_addr),
    .rd_data(rd_data), .rd_oe(rd_oe)
  );

  function automatic logic [18:0] exp_phys(input logic [15:0] a, input logic [4:0] b);
    if (a[15:14] == 2'b10) return {b, a[13:0]};
    return {3'b000, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = 16'h0000; cpu_wdata = 8'h00;
  endtask

  task automatic probe_map(input string req, input logic [15:0] a);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = a;
    #1;
    chk(req, 32'(phys_addr), 32'(exp_phys(a, model_bank)));
    chk({req, "_lowbits"}, 32'(phys_addr[13:0]), 32'(a[13:0]));
  endtask

  task automatic read_bank(input string req);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b1; cpu_addr = 16'hDE80;
    #1;
    chk({req, "_oe"}, 32'(rd_oe), 32'd1);
    chk({req, "_data"}, 32'(rd_data), 32'({3'b000, model_bank}));
  endtask

  task automatic write_bank(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk);
    if (a[15:8] == 8'hDE) model_bank = d[4:0];
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    idle();
    read_bank("R1_in_reset");
    probe_map("R1_win_in_reset", 16'h9ABC);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    read_bank("R1_after_reset");
    probe_map("R1_win_after", 16'h8001);
  endtask

  task automatic t_outside();
    probe_map("R5_zero", 16'h0000);
    probe_map("R5_low", 16'h4123);
    probe_map("R5_edge7fff", 16'h7FFF);
    probe_map("R5_c000", 16'hC000);
    probe_map("R5_ffff", 16'hFFFF);
    probe_map("R5_io", 16'hDE55);
  endtask

  task automatic t_load_same_cycle();
    @(negedge clk);
    cpu_wr = 1'b1; cpu_rd = 1'b1; cpu_addr = 16'hDE10; cpu_wdata = 8'hF7;
    #1;
    chk("R7_old_value_same_cycle", 32'(rd_data), 32'({3'b000, model_bank}));
    @(posedge clk);
    model_bank = 5'h17;
    read_bank("R3_R7_new_value");
    probe_map("R4_win_8000", 16'h8000);
    probe_map("R4_win_bfff", 16'hBFFF);
    chk("R4_bfff_abs", 32'(phys_addr), 32'h5FFFF);
    probe_map("R5_bank_nonzero_7fff", 16'h7FFF);
    probe_map("R5_bank_nonzero_c000", 16'hC000);
  endtask

  task automatic t_ignored();
    write_bank(16'hDF00, 8'h03);
    write_bank(16'hDDFF, 8'h05);
    write_bank(16'h8000, 8'h09);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0; cpu_addr = 16'hDE00; cpu_wdata = 8'h0A;
    @(posedge clk);
    #1;
    chk("R6_no_strobe_oe", 32'(rd_oe), 32'd0);
    chk("R6_no_strobe_data", 32'(rd_data), 32'd0);
    read_bank("R8_unchanged");
    @(negedge clk);
    cpu_rd = 1'b1; cpu_addr = 16'hDF00;
    #1;
    chk("R6_other_page_oe", 32'(rd_oe), 32'd0);
    chk("R6_other_page_data", 32'(rd_data), 32'd0);
  endtask

  task automatic t_extremes();
    write_bank(16'hDEFF, 8'hFF);
    read_bank("R3_max");
    probe_map("R4_max_a000", 16'hA000);
    chk("R4_max_abs", 32'(phys_addr), 32'h7E000);
    probe_map("R5_max_4000", 16'h4000);
    write_bank(16'hDE00, 8'hE0);
    read_bank("R3_upper_bits_ignored");
    probe_map("R4_bank0_8000", 16'h8000);
    chk("R4_bank0_abs", 32'(phys_addr), 32'h00000);
    write_bank(16'hDE42, 8'h0C);
    read_bank("R3_mid");
  endtask

  task automatic t_midrun_reset();
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    rst_n = 1'b0;
    model_bank = 5'd0;
    #1;
    read_bank("R1_async_clear");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    probe_map("R1_after_midrun", 16'hB123);
  endtask

  initial begin
    cpu_addr = 16'h0; cpu_wdata = 8'h0; cpu_wr = 1'b0; cpu_rd = 1'b0; rst_n = 1'b0;
    t_reset();
    t_outside();
    t_load_same_cycle();
    t_ignored();
    t_extremes();
    t_midrun_reset();
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule